// File: doc/BRIEF.md
# Threshold On/Off Express Credit Controller

This block sits at the input side of a downstream mesh router. It keeps a count of the free flit slots in one shared buffer pool. From that count it decides, for every upstream sender distance k from 1 up to a maximum express length, whether senders k hops away may keep sending (ON) or must pause (OFF). Express senders need more slack than one-hop senders. A token that tells them to stop takes k cycles to reach them, and up to 2k − 1 of their flits may already be travelling. Each distance is therefore gated against its own threshold of 3k − 1 free slots.

Each distance has a small two-state machine, with states `GATE_ON` and `GATE_OFF`. Transition `stop` (GATE_ON→GATE_OFF) is taken when the free count is strictly below that distance's threshold. Transition `start` (GATE_OFF→GATE_ON) is taken when the count is strictly above it. A count equal to the threshold holds the current state, which gives hysteresis. A separate pulse output marks the cycle in which a distance's level has just changed, so the token wiring sends only on transitions. In hybrid mode, threshold gating applies only to distances up to three hops. Longer distances are held in `GATE_ON` and are left to other signalling. The free count steps down on an allocate strobe and up on a release strobe.

Top module: `express_onoff_ctrl`

## Requirements
- R1: After reset the free count equals POOL_SIZE, every bit of `path_on` is 1 and every bit of `path_flip` is 0.
- R2: An allocate strobe lowers the free count by one and a release strobe raises it by one. Both strobes in the same cycle leave the count unchanged.
- R3: The free count saturates: an allocate at 0 leaves it at 0, and a release at POOL_SIZE leaves it at POOL_SIZE.
- R4: Bit k−1 of `path_on` belongs to distance k, and its threshold is 3k − 1 free slots. Distances are gated independently of one another.
- R5: A distance in GATE_ON moves to GATE_OFF when the free count is below its threshold. The registered level shows the change one clock edge after the count shows it, which is two edges after the strobe.
- R6: A distance in GATE_OFF moves to GATE_ON only when the free count is above its threshold. A count equal to the threshold keeps the current level.
- R7: Bit k−1 of `path_flip` is 1 for exactly the one cycle in which bit k−1 of `path_on` has just changed, and is 0 in every other cycle.
- R8: With HYBRID=1, distances greater than 3 stay ON and never pulse, whatever the free count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| buf_alloc | input | 1 | One slot taken from the pool this cycle |
| buf_release | input | 1 | One slot returned to the pool this cycle |
| path_on | output | LMAX | Per-distance send-permission level, bit k−1 for distance k |
| path_flip | output | LMAX | One-cycle pulse on a level change, per distance |

## Verification
The bench builds two copies with POOL_SIZE=16 and LMAX=5, one with HYBRID=0 and one with HYBRID=1, and drives both with the same strobes. This gives thresholds of 2, 5, 8, 11 and 14. Every distance can then be crossed in both directions inside a 16-slot pool, and the hybrid copy shows distances 4 and 5 staying ON while the plain copy turns them OFF. The stimulus walks the count onto each threshold exactly, to show the hysteresis hold. It also pushes past both saturation ends, so that a count that wraps or a comparison that is off by one changes a visible level.

// File: rtl/express_onoff_pkg.sv
package express_onoff_pkg;

    typedef enum logic {
        GATE_ON  = 1'b0,
        GATE_OFF = 1'b1
    } gate_state_e;

    // free-slot threshold for a sender k hops away: token delay k plus 2k-1 in flight
    function automatic int unsigned dist_threshold(input int unsigned k);
        return 3 * k - 1;
    endfunction

endpackage

// File: rtl/slot_counter.sv
module slot_counter #(
    parameter int unsigned POOL_SIZE = 16,
    parameter int unsigned CNT_W     = $clog2(POOL_SIZE + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             give,
    output logic [CNT_W-1:0] free_cnt
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(POOL_SIZE);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (take && !give) begin
            if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
        end else if (give && !take) begin
            if (cnt_q != FULL) cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= FULL;
        else        cnt_q <= cnt_d;
    end

    assign free_cnt = cnt_q;

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL);

    assert_both_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && give) |=> (cnt_q == $past(cnt_q)));

    assert_step_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !give && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/hop_gate.sv
module hop_gate
    import express_onoff_pkg::*;
#(
    parameter int unsigned CNT_W = 5,
    parameter int unsigned THR   = 2,
    parameter bit          GATED = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] free_cnt,
    output logic             level_on,
    output logic             flip
);
    localparam logic [CNT_W-1:0] THR_V = CNT_W'(THR);

    gate_state_e state_q;
    gate_state_e state_d;
    logic        flip_q;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_ON:  if (GATED && (free_cnt < THR_V))  state_d = GATE_OFF; // stop
            GATE_OFF: if (!GATED || (free_cnt > THR_V)) state_d = GATE_ON;  // start
            default:  state_d = GATE_ON;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= GATE_ON;
        else        state_q <= state_d;
    end

    // output register: pulse marks the edge that changed the state
    always_ff @(posedge clk) begin
        if (!rst_n) flip_q <= 1'b0;
        else        flip_q <= (state_d != state_q);
    end

    assign level_on = (state_q == GATE_ON);
    assign flip     = flip_q;

    assert_stop_below_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(level_on) |-> ($past(free_cnt) < THR_V));

    assert_start_above_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(level_on) |-> ($past(free_cnt) > THR_V));

    assert_pulse_on_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flip |-> (level_on != $past(level_on)));

    assert_change_has_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (level_on != $past(level_on)) |-> flip);

    generate
        if (!GATED) begin : g_free_run
            assert_ungated_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
                level_on && !flip);
        end
    endgenerate

endmodule

// File: rtl/express_onoff_ctrl.sv
module express_onoff_ctrl
    import express_onoff_pkg::*;
#(
    parameter int unsigned POOL_SIZE = 16,
    parameter int unsigned LMAX      = 4,
    parameter bit          HYBRID    = 1'b0,
    parameter int unsigned SHORT_MAX = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            buf_alloc,
    input  logic            buf_release,
    output logic [LMAX-1:0] path_on,
    output logic [LMAX-1:0] path_flip
);
    localparam int unsigned CNT_W = $clog2(POOL_SIZE + 1);

    logic [CNT_W-1:0] free_cnt;

    slot_counter #(
        .POOL_SIZE (POOL_SIZE),
        .CNT_W     (CNT_W)
    ) u_pool (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (buf_alloc),
        .give     (buf_release),
        .free_cnt (free_cnt)
    );

    generate
        for (genvar k = 1; k <= LMAX; k++) begin : g_dist
            localparam bit GATE_THIS = !HYBRID || (k <= SHORT_MAX);
            hop_gate #(
                .CNT_W (CNT_W),
                .THR   (dist_threshold(k)),
                .GATED (GATE_THIS)
            ) u_gate (
                .clk      (clk),
                .rst_n    (rst_n),
                .free_cnt (free_cnt),
                .level_on (path_on[k-1]),
                .flip     (path_flip[k-1])
            );
        end
    endgenerate

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (path_on == '1 && path_flip == '0));

endmodule

// File: tb/express_onoff_ctrl_tb.sv
module express_onoff_ctrl_tb;
    localparam int POOL = 16;
    localparam int LM   = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic buf_alloc = 1'b0;
    logic buf_release = 1'b0;
    logic [LM-1:0] on_a, flip_a, on_b, flip_b;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    always #4 clk = ~clk;

    express_onoff_ctrl #(.POOL_SIZE(POOL), .LMAX(LM), .HYBRID(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .buf_alloc(buf_alloc), .buf_release(buf_release),
        .path_on(on_a), .path_flip(flip_a));

    express_onoff_ctrl #(.POOL_SIZE(POOL), .LMAX(LM), .HYBRID(1'b1)) u_dut_hybrid (
        .clk(clk), .rst_n(rst_n), .buf_alloc(buf_alloc), .buf_release(buf_release),
        .path_on(on_b), .path_flip(flip_b));

    // behavioural reference: integer pool plus per-distance level bits
    int m_free;
    bit m_on   [2][LM];
    bit m_flip [2][LM];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_free = POOL;
            for (int v = 0; v < 2; v++)
                for (int k = 0; k < LM; k++) begin
                    m_on[v][k] = 1; m_flip[v][k] = 0;
                end
        end else begin
            for (int v = 0; v < 2; v++)
                for (int k = 1; k <= LM; k++) begin
                    int thr;
                    bit nxt;
                    thr = 3 * k - 1;
                    nxt = m_on[v][k-1];
                    if (!(v == 1 && k > 3)) begin
                        if (nxt && m_free < thr) nxt = 0;
                        else if (!nxt && m_free > thr) nxt = 1;
                    end
                    m_flip[v][k-1] = (nxt != m_on[v][k-1]);
                    m_on[v][k-1] = nxt;
                end
            if (buf_alloc && !buf_release && m_free > 0) m_free--;
            else if (buf_release && !buf_alloc && m_free < POOL) m_free++;
        end
    end

    task automatic check(input string tag, input logic [LM-1:0] act, input logic [LM-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model, away from the clock edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [LM-1:0] e_on_a, e_fl_a, e_on_b, e_fl_b;
            for (int k = 0; k < LM; k++) begin
                e_on_a[k] = m_on[0][k]; e_fl_a[k] = m_flip[0][k];
                e_on_b[k] = m_on[1][k]; e_fl_b[k] = m_flip[1][k];
            end
            check("R4 R5 R6 level per distance", on_a, e_on_a);
            check("R7 change pulse", flip_a, e_fl_a);
            check("R8 hybrid level", on_b, e_on_b);
            check("R8 R7 hybrid pulse", flip_b, e_fl_b);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic strobe(input bit a, input bit r, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            buf_alloc = a; buf_release = r;
        end
        @(negedge clk);
        buf_alloc = 0; buf_release = 0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset level", on_a, 5'b11111);
        check("R1 reset pulse", flip_a, 5'b00000);
        // releases at full pool must not push the count past 16
        strobe(0, 1, 4);
        strobe(1, 0, 5);                          // free = 11
        check("R3 top saturation, R4 k4 at thr 11", on_a, 5'b01111);
        strobe(1, 0, 1);                          // free = 10
        check("R4 k4 stops below 11", on_a, 5'b00111);
        check("R8 hybrid k4 k5 held on", on_b, 5'b11111);
        strobe(1, 1, 3);                          // unchanged
        check("R2 simultaneous strobes", on_a, 5'b00111);
        strobe(1, 0, 8);                          // free = 2
        check("R6 k1 equal to thr 2 holds on", on_a, 5'b00001);
        check("R8 hybrid at free 2", on_b, 5'b11001);
        strobe(1, 0, 1);                          // free = 1
        check("R5 k1 stops at free 1", on_a, 5'b00000);
        check("R8 hybrid at free 1", on_b, 5'b11000);
        strobe(0, 1, 1);                          // free = 2
        check("R6 hysteresis at equality", on_a, 5'b00000);
        strobe(0, 1, 1);                          // free = 3
        check("R6 k1 restarts above thr", on_a, 5'b00001);
        strobe(1, 0, 10);                         // saturates at 0
        strobe(0, 1, 3);                          // free = 3
        check("R3 bottom saturation", on_a, 5'b00001);
        strobe(0, 1, 3);                          // free = 6
        check("R4 k2 restarts above 5", on_a, 5'b00011);
        strobe(0, 1, 10);                         // free = 16
        check("R6 all restart at full pool", on_a, 5'b11111);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule